// File: doc/BRIEF.md
# Phase-Accumulating Tone Generator with One-Bit Correlator

The block is a numerically controlled oscillator that also acts as a single-bin correlator. A 32-bit phase register advances by a programmable step on every clock. Its top nine bits select an entry of a 512-entry signed sine table. That entry, shifted to offset binary, drives an 8-bit converter code that may change on every clock. So the block can synthesise a carrier at any frequency up to the Nyquist limit of the clock, with frequency resolution of one part in 2^32.

The same table also supplies the reference for a correlator fed by a one-bit sigma-delta bitstream. The table gives the sine entry directly and the cosine entry at a quarter-cycle address offset. Each clock, both entries are added to two signed accumulators when the incoming bit is 1 and subtracted when it is 0. After a programmed number of samples, both sums are copied to the result outputs and the accumulators start again from zero. A one-cycle done strobe marks each new result, so software or a neighbouring block can read one in-phase/quadrature pair per window.

Configuration uses a single write strobe with a one-bit register select. Select 0 loads the frequency step. Select 1 loads the window length and restarts the current window.

Top module: `tone_correlator`

## Requirements
- R1: On every rising clock edge, the phase register becomes its old value plus the frequency step, modulo 2^32. After reset both the phase and the step are 0.
- R2: Table entry k (0..511) equals round(127 * 16p / (327680 - 4p)) with p = j*(256-j) and j = k mod 256, with halves rounded up. The entry is negated for k >= 256.
- R3: After each edge, dac_code equals T[a] + 128, where a is phase bits 31:23 as they stood before that edge. The code changes on every clock. After reset it is 128.
- R4: A write with cfg_sel = 0 loads cfg_wdata as the new step. The edge after the write already advances the phase by the new step. The phase is never cleared by such a write, so the output stays phase-continuous.
- R5: The cosine reference for address a is T[(a + 128) mod 512].
- R6: On each edge, the sine accumulator gains +T[a] when adc_bit is 1 and -T[a] when it is 0. The cosine accumulator does the same with the cosine reference. Both accumulators are 32-bit signed.
- R7: A write with cfg_sel = 1 sets the window length N from cfg_wdata bits 15:0 and clears both accumulators and the sample count at that edge. The N samples taken on the following edges form one window, with N = 0 meaning 65536. After the edge that takes the N-th sample, corr_sin and corr_cos hold the window sums and corr_done is 1 for that one cycle (every cycle when N = 1). The next window begins on the following edge with no gap. After reset, N is 0.
- R8: corr_sin and corr_cos change only in a cycle where corr_done is 1. Between done strobes they hold their last values. After reset they are 0 and corr_done is 0.
- R9: rst_n clears the block asynchronously when it falls. The internal reset is released two clock edges after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 frequency step, 1 window length |
| cfg_wdata | input | 32 | Configuration write data |
| adc_bit | input | 1 | One-bit sigma-delta bitstream sample |
| dac_code | output | 8 | Offset-binary converter code |
| corr_sin | output | 32 | Signed sine correlation of the last window |
| corr_cos | output | 32 | Signed cosine correlation of the last window |
| corr_done | output | 1 | One-cycle strobe for a new result |

## Verification
On every cycle, the assertions check several properties. The code is mid-scale when the previous address was a zero crossing and full-scale at the quarter-cycle peak. The phase step stays constant between frequency writes. Results hold between done strobes, and each done arrives after exactly the programmed number of samples with the accumulators cleared. The exact table contents, the cosine offset and the sums for particular bitstreams can only be shown by the bench's scenarios. These scenarios include a sweep over all 512 addresses on both table ports, several bitstream patterns, back-to-back windows, the full 65536-sample window and an asynchronous reset in the middle of a run.

// File: rtl/tone_pkg.sv
package tone_pkg;

  // Signed sine magnitude by a rational approximation on the half wave,
  // rounded to nearest; negated on the second half of the table.
  function automatic int sine_entry(int idx, int aw, int amp_w);
    longint half;
    longint j;
    longint p;
    longint amp;
    longint num;
    longint den;
    longint mag;
    half = longint'(1) << (aw - 1);
    j    = longint'(idx) % half;
    p    = j * (half - j);
    amp  = (longint'(1) << (amp_w - 1)) - 1;
    num  = 32 * amp * p;
    den  = 5 * half * half - 4 * p;
    mag  = (num + den) / (2 * den);
    if (longint'(idx) >= half) return -int'(mag);
    return int'(mag);
  endfunction

endpackage

// File: rtl/tone_rst_sync.sv
module tone_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tone_phase.sv
module tone_phase #(
  parameter int PHASE_W = 32,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [PHASE_W-1:0] cfg_wdata,
  output logic [PHASE_W-1:0] phase_q,
  output logic [CNT_W-1:0]   win_len,
  output logic               win_restart
);
  logic [PHASE_W-1:0] step_q;
  logic [PHASE_W-1:0] step_d;
  logic [PHASE_W-1:0] phase_d;
  logic [CNT_W-1:0]   win_d;
  logic               step_en;
  logic               win_en;

  always_comb begin
    step_en = cfg_we & ~cfg_sel;
    win_en  = cfg_we & cfg_sel;
    step_d  = cfg_wdata;
    win_d   = cfg_wdata[CNT_W-1:0];
    phase_d = phase_q + step_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      step_q  <= '0;
      win_len <= '0;
    end else begin
      phase_q <= phase_d;
      if (step_en) step_q  <= step_d;
      if (win_en)  win_len <= win_d;
    end
  end

  assign win_restart = win_en;
endmodule

// File: rtl/tone_sine_rom.sv
module tone_sine_rom #(
  parameter int AW    = 9,
  parameter int AMP_W = 8
) (
  input  logic [AW-1:0]           addr,
  output logic signed [AMP_W-1:0] sin_v,
  output logic signed [AMP_W-1:0] cos_v
);
  localparam int            DEPTH   = 1 << AW;
  localparam logic [AW-1:0] QUARTER = AW'(DEPTH / 4);

  logic signed [AMP_W-1:0] rom [DEPTH];
  logic [AW-1:0]           cos_addr;

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    assign rom[k] = AMP_W'(tone_pkg::sine_entry(k, AW, AMP_W));
  end

  assign cos_addr = addr + QUARTER;
  assign sin_v    = rom[addr];
  assign cos_v    = rom[cos_addr];
endmodule

// File: rtl/tone_corr.sv
module tone_corr #(
  parameter int ACC_W = 32,
  parameter int AMP_W = 8,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    win_restart,
  input  logic [CNT_W-1:0]        win_len,
  input  logic                    adc_bit,
  input  logic signed [AMP_W-1:0] sin_v,
  input  logic signed [AMP_W-1:0] cos_v,
  output logic signed [ACC_W-1:0] acc_sin,
  output logic signed [ACC_W-1:0] acc_cos,
  output logic signed [ACC_W-1:0] res_sin,
  output logic signed [ACC_W-1:0] res_cos,
  output logic                    done
);
  logic signed [ACC_W-1:0] term_s, term_c;
  logic signed [ACC_W-1:0] sum_s, sum_c;
  logic signed [ACC_W-1:0] acc_s_d, acc_c_d;
  logic [CNT_W-1:0]        cnt_q, cnt_d;
  logic                    last, res_en, done_d;

  always_comb begin
    term_s = ACC_W'(sin_v);
    term_c = ACC_W'(cos_v);
    if (!adc_bit) begin
      term_s = -term_s;
      term_c = -term_c;
    end
    sum_s  = acc_sin + term_s;
    sum_c  = acc_cos + term_c;
    last   = (cnt_q == win_len - CNT_W'(1));
    res_en = last & ~win_restart;
    if (win_restart) begin
      acc_s_d = '0;
      acc_c_d = '0;
      cnt_d   = '0;
      done_d  = 1'b0;
    end else if (last) begin
      acc_s_d = '0;
      acc_c_d = '0;
      cnt_d   = '0;
      done_d  = 1'b1;
    end else begin
      acc_s_d = sum_s;
      acc_c_d = sum_c;
      cnt_d   = cnt_q + CNT_W'(1);
      done_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_sin <= '0;
      acc_cos <= '0;
      cnt_q   <= '0;
      done    <= 1'b0;
      res_sin <= '0;
      res_cos <= '0;
    end else begin
      acc_sin <= acc_s_d;
      acc_cos <= acc_c_d;
      cnt_q   <= cnt_d;
      done    <= done_d;
      if (res_en) begin
        res_sin <= sum_s;
        res_cos <= sum_c;
      end
    end
  end
endmodule

// File: rtl/tone_correlator.sv
module tone_correlator #(
  parameter int PHASE_W = 32,
  parameter int TBL_AW  = 9,
  parameter int AMP_W   = 8,
  parameter int ACC_W   = 32,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [PHASE_W-1:0] cfg_wdata,
  input  logic               adc_bit,
  output logic [AMP_W-1:0]   dac_code,
  output logic [ACC_W-1:0]   corr_sin,
  output logic [ACC_W-1:0]   corr_cos,
  output logic               corr_done
);
  localparam logic [AMP_W-1:0] MID = AMP_W'(1) << (AMP_W - 1);

  logic                    rst_sync_n;
  logic [PHASE_W-1:0]      phase_q;
  logic [CNT_W-1:0]        win_len;
  logic                    win_restart;
  logic [TBL_AW-1:0]       tbl_addr;
  logic signed [AMP_W-1:0] sin_v, cos_v;
  logic signed [ACC_W-1:0] acc_sin, acc_cos, res_sin, res_cos;
  logic [AMP_W-1:0]        dac_q, dac_d;

  tone_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tone_phase #(.PHASE_W(PHASE_W), .CNT_W(CNT_W)) u_phase (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .phase_q     (phase_q),
    .win_len     (win_len),
    .win_restart (win_restart)
  );

  assign tbl_addr = phase_q[PHASE_W-1 -: TBL_AW];

  tone_sine_rom #(.AW(TBL_AW), .AMP_W(AMP_W)) u_rom (
    .addr  (tbl_addr),
    .sin_v (sin_v),
    .cos_v (cos_v)
  );

  tone_corr #(.ACC_W(ACC_W), .AMP_W(AMP_W), .CNT_W(CNT_W)) u_corr (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .win_restart (win_restart),
    .win_len     (win_len),
    .adc_bit     (adc_bit),
    .sin_v       (sin_v),
    .cos_v       (cos_v),
    .acc_sin     (acc_sin),
    .acc_cos     (acc_cos),
    .res_sin     (res_sin),
    .res_cos     (res_cos),
    .done        (corr_done)
  );

  always_comb dac_d = $unsigned(sin_v) + MID;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) dac_q <= MID;
    else             dac_q <= dac_d;
  end

  assign dac_code = dac_q;
  assign corr_sin = res_sin;
  assign corr_cos = res_cos;
endmodule

// File: rtl/tone_correlator_chk.sv
module tone_correlator_chk #(
  parameter int PHASE_W = 32,
  parameter int TBL_AW  = 9,
  parameter int AMP_W   = 8,
  parameter int ACC_W   = 32,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               cfg_we,
  input logic               cfg_sel,
  input logic [PHASE_W-1:0] phase_q,
  input logic [CNT_W-1:0]   win_len,
  input logic [AMP_W-1:0]   dac_code,
  input logic               corr_done,
  input logic [ACC_W-1:0]   corr_sin,
  input logic [ACC_W-1:0]   corr_cos,
  input logic [ACC_W-1:0]   acc_sin,
  input logic [ACC_W-1:0]   acc_cos
);
  localparam logic [AMP_W-1:0] MID  = AMP_W'(1) << (AMP_W - 1);
  localparam logic [AMP_W-1:0] PEAK = MID + (MID - AMP_W'(1));

  logic [1:0]     hist_q;
  logic [CNT_W:0] samp_q;
  logic [CNT_W:0] exp_len;
  logic           step_wr;

  assign step_wr = cfg_we & ~cfg_sel;
  assign exp_len = (win_len == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, win_len};

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hist_q <= '0;
      samp_q <= '0;
    end else begin
      if (hist_q != 2'd3) hist_q <= hist_q + 2'd1;
      if (cfg_we && cfg_sel) samp_q <= '0;
      else if (corr_done)    samp_q <= (CNT_W+1)'(1);
      else                   samp_q <= samp_q + (CNT_W+1)'(1);
    end
  end

  a_r8_results_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !corr_done |-> ($stable(corr_sin) && $stable(corr_cos)));

  a_r4_step_constant: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hist_q == 2'd3 && !$past(step_wr, 2)) |->
      ((phase_q - $past(phase_q)) == ($past(phase_q) - $past(phase_q, 2))));

  a_r3_dac_zero_cross: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hist_q != 2'd0 && $past(phase_q[PHASE_W-2 -: TBL_AW-1]) == '0) |->
      (dac_code == MID));

  a_r3_dac_peak: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hist_q != 2'd0 && $past(phase_q[PHASE_W-1 -: TBL_AW]) == TBL_AW'(1 << (TBL_AW - 2))) |->
      (dac_code == PEAK));

  a_r7_window_length: assert property (@(posedge clk) disable iff (!rst_sync_n)
    corr_done |-> (samp_q == exp_len));

  a_r7_acc_cleared: assert property (@(posedge clk) disable iff (!rst_sync_n)
    corr_done |-> (acc_sin == '0 && acc_cos == '0));
endmodule

bind tone_correlator tone_correlator_chk #(
  .PHASE_W (PHASE_W),
  .TBL_AW  (TBL_AW),
  .AMP_W   (AMP_W),
  .ACC_W   (ACC_W),
  .CNT_W   (CNT_W)
) i_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .cfg_we     (cfg_we),
  .cfg_sel    (cfg_sel),
  .phase_q    (phase_q),
  .win_len    (win_len),
  .dac_code   (dac_code),
  .corr_done  (corr_done),
  .corr_sin   (corr_sin),
  .corr_cos   (corr_cos),
  .acc_sin    (acc_sin),
  .acc_cos    (acc_cos)
);

// File: tb/test_tone_correlator.sv
`timescale 1ns/1ps
module test_tone_correlator;
  logic        clk, rst_n, cfg_we, cfg_sel, adc_bit;
  logic [31:0] cfg_wdata;
  logic [7:0]  dac_code;
  logic [31:0] corr_sin, corr_cos;
  logic        corr_done;

  int          n_tests, n_fail;
  logic [31:0] mph, mfreq;
  longint      exp_s, exp_c;
  logic [15:0] lfsr;
  string       tag;

  tone_correlator i_tone_correlator (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .adc_bit(adc_bit), .dac_code(dac_code),
    .corr_sin(corr_sin), .corr_cos(corr_cos), .corr_done(corr_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // R2: table value from the rational half-wave formula, evaluated in reals
  function automatic int tab(int idx);
    int  i, j, r;
    real p, v;
    i = idx & 511;
    j = i & 255;
    p = real'(j * (256 - j));
    v = 127.0 * 16.0 * p / (327680.0 - 4.0 * p);
    r = int'($rtoi($floor(v + 0.5)));
    return (i >= 256) ? -r : r;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One clock: drive inputs, update the arithmetic model, check the code (R2 R3).
  task automatic cyc(input logic a, input logic we = 1'b0,
                     input logic sel = 1'b0, input logic [31:0] d = 32'd0);
    int idx;
    idx = int'(mph[31:23]);
    adc_bit = a; cfg_we = we; cfg_sel = sel; cfg_wdata = d;
    if (a) begin
      exp_s += tab(idx);       exp_c += tab(idx + 128);
    end else begin
      exp_s -= tab(idx);       exp_c -= tab(idx + 128);
    end
    @(posedge clk);
    mph += mfreq;
    if (we && !sel) mfreq = d;
    if (we && sel) begin exp_s = 0; exp_c = 0; end
    @(negedge clk);
    cfg_we = 1'b0;
    check(tag, "dac_code", longint'(dac_code), longint'(tab(idx) + 128));
  endtask

  function automatic logic pat_bit(int pat, int i);
    case (pat)
      0:       return 1'b1;
      1:       return 1'b0;
      2:       return logic'(i & 1);
      3:       return (tab(int'(mph[31:23])) >= 0);
      default: return lfsr[0];
    endcase
  endfunction

  // R7: restart with length n, then run nwin windows of bitstream pattern pat
  task automatic win_test(int n, int pat, int nwin, string req);
    int     len;
    longint hs, hc;
    len = (n == 0) ? 65536 : n;
    tag = req;
    cyc(1'b0, 1'b1, 1'b1, 32'(n));
    for (int w = 0; w < nwin; w++) begin
      for (int i = 0; i < len; i++) begin
        cyc(pat_bit(pat, i));
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (len > 1 && (i == 0 || i == len - 2))
          check("R7", "corr_done early", longint'(corr_done), 0);
      end
      check("R7", "corr_done at window end", longint'(corr_done), 1);
      check(req, "corr_sin", longint'($signed(corr_sin)), exp_s);
      check(req, "corr_cos", longint'($signed(corr_cos)), exp_c);
      hs = exp_s; hc = exp_c;
      exp_s = 0; exp_c = 0;
      if (w == nwin - 1 && len > 1) begin
        cyc(1'b1);
        check("R7", "corr_done one cycle", longint'(corr_done), 0);
        check("R8", "corr_sin held", longint'($signed(corr_sin)), hs);
        check("R8", "corr_cos held", longint'($signed(corr_cos)), hc);
      end
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0;
    mph = 0; mfreq = 0; exp_s = 0; exp_c = 0; lfsr = 16'hACE1; tag = "R3";
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0; adc_bit = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cyc(1'b0);
    // R8 R9: reset state
    check("R8", "corr_done after reset", longint'(corr_done), 0);
    check("R8", "corr_sin after reset", longint'(corr_sin), 0);
    check("R8", "corr_cos after reset", longint'(corr_cos), 0);
    check("R9", "dac_code after reset", longint'(dac_code), 128);

    // R2 R3: one table entry per clock over every address
    tag = "R2";
    cyc(1'b0, 1'b1, 1'b0, 32'h0080_0000);
    for (int i = 0; i < 520; i++) cyc(1'b0);

    // R1 R4: step changes without phase reset, including a negative step
    tag = "R4";
    cyc(1'b0, 1'b1, 1'b0, 32'h00C0_0000);
    for (int i = 0; i < 200; i++) cyc(1'b0);
    cyc(1'b0, 1'b1, 1'b0, 32'h0123_4567);
    for (int i = 0; i < 300; i++) cyc(1'b0);
    tag = "R1";
    cyc(1'b0, 1'b1, 1'b0, 32'hFF9F_0001);
    for (int i = 0; i < 200; i++) cyc(1'b0);

    // R5 R6: single-sample windows expose both references at every address
    cyc(1'b0, 1'b1, 1'b0, 32'h0080_0000);
    win_test(1, 0, 520, "R5");

    // R6: several bitstream patterns, two back-to-back windows each
    tag = "R6";
    cyc(1'b0, 1'b1, 1'b0, 32'h0123_4567);
    for (int p = 0; p < 5; p++) win_test(300, p, 2, "R6");

    // R7: short windows, restart in the middle of a run
    win_test(7, 4, 3, "R7");
    for (int i = 0; i < 3; i++) cyc(1'b1);
    win_test(2, 2, 2, "R7");
    // R7: length 0 means 65536 samples; whole carrier cycles sum to 0
    cyc(1'b0, 1'b1, 1'b0, 32'h0080_0000);
    win_test(0, 0, 1, "R7");
    check("R7", "full window sine sum", longint'($signed(corr_sin)), 0);

    // R9: asynchronous assertion mid-run, synchronous release
    cyc(1'b0, 1'b1, 1'b0, 32'h0123_4567);
    for (int i = 0; i < 5; i++) cyc(1'b1);
    #1 rst_n = 1'b0;
    #0.5;
    check("R9", "dac_code async reset", longint'(dac_code), 128);
    check("R9", "corr_sin async reset", longint'(corr_sin), 0);
    check("R9", "corr_done async reset", longint'(corr_done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    mph = 0; mfreq = 0; exp_s = 0; exp_c = 0; tag = "R9";
    for (int i = 0; i < 4; i++) cyc(1'b1);
    check("R9", "corr_cos after release", longint'(corr_cos), 0);

    summary();
    $finish;
  end
endmodule